// File: doc/BRIEF.md
# Conditional Skip and Jump Sequencer

This unit decides how the program counter moves after a flow-control command. On a start strobe it samples an 8-bit command byte, the two 8-bit operand caches, a command argument, the content of the register that the argument names, and the current program counter. It then either compares the two caches or takes a jump target. After the command's own cycle count, it raises a one-cycle completion pulse together with a load enable for the program counter. In the same cycle it presents the next program counter, the increment that was applied, and whether a skip was taken.

Branching works by skipping. When a comparison holds, the two instructions after the current one are passed over, so the counter advances by three instruction widths. When it does not hold, the counter advances by one width. Bit 7 of a compare command selects unsigned operands; when it is clear, the operands are two's complement. The low three bits select the relation. Two jump commands load the counter from a register or from the argument itself. A no-operation command only advances the counter. The register file and the program counter storage sit outside this unit.

Top module: `skip_unit`

## Requirements
- R1: After a synchronous active-low reset, done, pc_load, skip, pc_inc and pc_next are all zero.
- R2: Commands 0x21 to 0x26 (bit 7 clear) compare c0 with c1 as two's-complement values. The relation is chosen by cmd[2:0]: 1 greater, 2 equal, 3 greater-or-equal, 4 less, 5 not-equal, 6 less-or-equal. skip is 1 exactly when c0 <relation> c1.
- R3: Commands 0xA1 to 0xA6 apply the same relation codes to c0 and c1 taken as unsigned values.
- R4: Commands 0x20 and 0xA0 never skip and finish in 2 cycles.
- R5: Commands 0x27 and 0xA7 always skip and finish in 3 cycles.
- R6: A command takes N cycles. The edge that samples start is the first edge, and done is high in the cycle after the N-th edge. A conditional compare takes 3 cycles when its skip is taken and 2 when it is not.
- R7: For every compare or no-operation command, pc_next = pc + pc_inc modulo 2^PC_W, where pc is the value sampled with start. pc_inc is 3*INSTR_BYTES on a skip and INSTR_BYTES otherwise.
- R8: Command 0x28 loads pc_next with reg_val and command 0xA8 loads it with arg. Both take 4 cycles, with skip = 0 and pc_inc = 0.
- R9: Command 0x00 takes 2 cycles, with skip = 0 and pc_inc = INSTR_BYTES.
- R10: done and pc_load are high together for exactly one cycle per command. skip, pc_inc and pc_next hold their values until the next completion.
- R11: A start that arrives while a command is in progress, up to and including its completion edge, is ignored. A start with any command other than those in R2 to R9 is also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin the command on cmd |
| cmd | input | 8 | Command byte |
| arg | input | 8 | Command argument (immediate jump target) |
| c0 | input | 8 | Operand cache 0 |
| c1 | input | 8 | Operand cache 1 |
| reg_val | input | 8 | Content of the register named by arg |
| pc | input | PC_W (8) | Current program counter |
| done | output | 1 | Completion pulse |
| pc_load | output | 1 | Program counter load enable |
| skip | output | 1 | Skip taken |
| pc_inc | output | INC_W (3) | Increment applied to pc |
| pc_next | output | PC_W (8) | Next program counter |

## Verification
Every relation code in both families is applied to a fixed set of operand pairs. Equal operands separate the equality relations from the strict ones. The pairs 0x80/0x01 and 0x7F/0xFF order differently when read signed and unsigned, so they expose a swapped or missing sign selection. A small pair with the larger value in c1 catches reversed operands. The two jumps use distinct register and immediate values, so a mix-up between the two sources shows. Unsupported command bytes, and a start held across a busy window that carries a different command, show whether the unit accepts commands it should ignore, as seen by a reference model that predicts done on every cycle.

// File: rtl/skip_unit.sv
module skip_unit #(
  parameter int PC_W = 8,
  parameter int INSTR_BYTES = 2,
  localparam int INC_W = $clog2(3 * INSTR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       cmd,
  input  logic [7:0]       arg,
  input  logic [7:0]       c0,
  input  logic [7:0]       c1,
  input  logic [7:0]       reg_val,
  input  logic [PC_W-1:0]  pc,
  output logic             done,
  output logic             pc_load,
  output logic             skip,
  output logic [INC_W-1:0] pc_inc,
  output logic [PC_W-1:0]  pc_next
);

  localparam logic [INC_W-1:0] INC_ONE  = INC_W'(INSTR_BYTES);
  localparam logic [INC_W-1:0] INC_SKIP = INC_W'(3 * INSTR_BYTES);

  logic             busy;
  logic [1:0]       cnt;
  logic             p_skip;
  logic [INC_W-1:0] p_inc;
  logic [PC_W-1:0]  p_next;
  logic             cond, take, acc;
  logic [1:0]       wait_n;
  logic [INC_W-1:0] inc;

  wire is_cmp = (cmd[6:3] == 4'b0100);
  wire is_jmp = (cmd[6:0] == 7'h28);
  wire is_nop = (cmd == 8'h00);
  wire sgn    = ~cmd[7];
  wire [8:0] a = {sgn & c0[7], c0};
  wire [8:0] b = {sgn & c1[7], c1};
  wire gt = $signed(a) > $signed(b);
  wire eq = (c0 == c1);

  always_comb begin
    case (cmd[2:0])
      3'd0: cond = 1'b0;
      3'd1: cond = gt;
      3'd2: cond = eq;
      3'd3: cond = gt | eq;
      3'd4: cond = ~gt & ~eq;
      3'd5: cond = ~eq;
      3'd6: cond = ~gt;
      default: cond = 1'b1;
    endcase
  end

  assign take   = is_cmp & cond;
  assign acc    = rst_n & start & ~busy & (is_cmp | is_jmp | is_nop);
  assign wait_n = is_jmp ? 2'd3 : (take ? 2'd2 : 2'd1);
  assign inc    = is_jmp ? '0 : (take ? INC_SKIP : INC_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0;
      p_skip <= 1'b0; p_inc <= '0; p_next <= '0;
      done <= 1'b0; pc_load <= 1'b0;
      skip <= 1'b0; pc_inc <= '0; pc_next <= '0;
    end else begin
      done    <= 1'b0;
      pc_load <= 1'b0;
      if (busy) begin
        if (cnt == 2'd1) begin
          busy <= 1'b0;
          done <= 1'b1; pc_load <= 1'b1;
          skip <= p_skip; pc_inc <= p_inc; pc_next <= p_next;
        end
        cnt <= cnt - 2'd1;
      end else if (acc) begin
        busy   <= 1'b1;
        cnt    <= wait_n;
        p_skip <= take;
        p_inc  <= inc;
        p_next <= is_jmp ? PC_W'(cmd[7] ? arg : reg_val) : pc + PC_W'(inc);
      end
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  skip_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && skip |-> pc_inc == INC_SKIP);

  // R4
  never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && cmd[6:0] == 7'h20) |=> done && !skip);

  // R5
  always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && cmd[6:0] == 7'h27, 2) |=> done && skip);

  // R8
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && is_jmp, 3) |=> done && !skip && pc_inc == '0);

endmodule

// File: tb/test_skip_unit.sv
module test_skip_unit;
  localparam int PC_W = 8;
  localparam int IB = 2;
  localparam int INC_W = $clog2(3 * IB + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] cmd = 0, arg = 0, c0 = 0, c1 = 0, reg_val = 0;
  logic [PC_W-1:0] pc = 0;
  logic done, pc_load, skip;
  logic [INC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_next;

  skip_unit #(.PC_W(PC_W), .INSTR_BYTES(IB)) i_skip_unit (
    .clk, .rst_n, .start, .cmd, .arg, .c0, .c1, .reg_val, .pc,
    .done, .pc_load, .skip, .pc_inc, .pc_next);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int e = 0, due = -1;
  bit m_done = 0, m_skip = 0, q_skip = 0;
  int m_inc = 0, m_next = 0, q_inc = 0, q_next = 0;
  string q_tag = "R9", m_tag = "R9";

  function automatic int sx(logic [7:0] v, bit s);
    return (s && v[7]) ? int'(v) - 256 : int'(v);
  endfunction

  function automatic bit rel(logic [7:0] cm, logic [7:0] x, logic [7:0] y);
    int a = sx(x, !cm[7]);
    int b = sx(y, !cm[7]);
    case (cm[2:0])
      0: return 0;
      1: return a > b;
      2: return a == b;
      3: return a >= b;
      4: return a < b;
      5: return a != b;
      6: return a <= b;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    e++;
    m_done = 0;
    if (!rst_n) begin
      due = -1; m_skip = 0; m_inc = 0; m_next = 0;
    end else begin
      if (e == due) begin
        m_done = 1; m_skip = q_skip; m_inc = q_inc; m_next = q_next; m_tag = q_tag;
      end
      if (start && due < e) begin
        if (cmd[6:3] == 4'b0100) begin
          int lat;
          q_skip = rel(cmd, c0, c1);
          lat = q_skip ? 3 : 2;
          q_inc = q_skip ? 3 * IB : IB;
          q_next = (int'(pc) + q_inc) % (1 << PC_W);
          q_tag = (cmd[2:0] == 0) ? "R4" : (cmd[2:0] == 7) ? "R5" : cmd[7] ? "R3" : "R2";
          due = e + lat - 1;
        end else if (cmd[6:0] == 7'h28) begin
          q_skip = 0; q_inc = 0; q_next = cmd[7] ? int'(arg) : int'(reg_val);
          q_tag = "R8"; due = e + 3;
        end else if (cmd == 8'h00) begin
          q_skip = 0; q_inc = IB; q_next = (int'(pc) + IB) % (1 << PC_W);
          q_tag = "R9"; due = e + 1;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk(done == m_done, "R6/R11 done", done, m_done);
    chk(pc_load == m_done, "R10 pc_load", pc_load, m_done);
    chk(skip == m_skip, m_done ? m_tag : "R10 held skip", skip, m_skip);
    chk(int'(pc_inc) == m_inc, m_done ? "R7 pc_inc" : "R10 held inc", pc_inc, m_inc);
    chk(int'(pc_next) == m_next, m_done ? "R7/R8 pc_next" : "R10 held next", pc_next, m_next);
  end

  task automatic op(logic [7:0] cm, logic [7:0] ag, logic [7:0] x, logic [7:0] y,
                    logic [7:0] rv, logic [PC_W-1:0] p);
    @(negedge clk);
    cmd = cm; arg = ag; c0 = x; c1 = y; reg_val = rv; pc = p; start = 1;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [7:0] pa [5] = '{8'h05, 8'h80, 8'h01, 8'h7F, 8'h03};
  logic [7:0] pb [5] = '{8'h05, 8'h01, 8'h80, 8'hFF, 8'h09};

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 0 && pc_load == 0, "R1 strobes", {done, pc_load}, 0);
    chk(skip == 0 && pc_inc == 0 && pc_next == 0, "R1 outputs", pc_next, 0);
    rst_n = 1;
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 8; r++)
        for (int k = 0; k < 5; k++)
          op({f[0], 4'b0100, r[2:0]}, 8'h00, pa[k], pb[k], 8'h00, PC_W'(8'hF0 + k * 3));
    op(8'h28, 8'h33, 8'h00, 8'h00, 8'h5A, 8'h10);   // R8 register jump
    op(8'hA8, 8'h33, 8'h00, 8'h00, 8'h5A, 8'h10);   // R8 immediate jump
    op(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF);   // R9 nop wrap
    op(8'h10, 8'h00, 8'h01, 8'h02, 8'h00, 8'h20);   // R11 unsupported
    op(8'h88, 8'h00, 8'h01, 8'h02, 8'h00, 8'h20);   // R11 unsupported
    op(8'h29, 8'h44, 8'h01, 8'h02, 8'h00, 8'h20);   // R11 unsupported
    // R11 start held while busy with a different command
    @(negedge clk);
    cmd = 8'h27; c0 = 1; c1 = 2; pc = 8'h40; start = 1;
    @(negedge clk);
    cmd = 8'hA8; arg = 8'h77;
    @(negedge clk);
    @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);
    // back-to-back: start in the completion cycle of the prior command
    @(negedge clk);
    cmd = 8'h22; c0 = 9; c1 = 9; pc = 8'h50; start = 1;
    repeat (3) @(negedge clk);
    cmd = 8'h00; pc = 8'h60;
    @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule